// File: doc/BRIEF.md
# Extended Float Class Examiner

This block inspects one 80-bit extended-precision operand and reports its class and sign as four condition bits, C3, C2, C1 and C0. The operand is laid out as a sign bit at position 79, a 15-bit biased exponent at positions 78:64, and a 64-bit significand at positions 63:0. Bit 63 of the significand is an explicit integer bit, so some exponent and significand pairs have no valid meaning. The block reports those as a separate unsupported class.

A second input tells the block that the register holding the operand is empty. An empty tag takes priority over every class decode. The sign is still reported in C1 because it comes straight from bit 79, whether the register is empty or full.

The block is purely combinational, with no clock and no state. A surrounding status unit samples the four bits wherever its own pipeline needs them. Internally the field decode produces one strobe per class, and a separate encoder turns the active strobe into the condition-code pattern.

Top module: `xfc_examiner`

## Requirements
- R1: With the empty tag high, C3=1, C2=0 and C0=1, whatever the operand holds.
- R2: A zero (exponent 0 and all 64 significand bits 0) gives C3=1, C2=0, C0=0.
- R3: A NaN (exponent all ones, bit 63 set, any of bits 62:0 nonzero) gives C3=0, C2=0, C0=1.
- R4: An unsupported operand gives C3=0, C2=0, C0=0. An operand is unsupported when its exponent is nonzero (all ones included) and bit 63 is clear.
- R5: An infinity (exponent all ones, bit 63 set, bits 62:0 zero) of either sign gives C3=0, C2=1, C0=1.
- R6: A denormal (exponent 0, significand nonzero, bit 63 set or clear) gives C3=1, C2=1, C0=0.
- R7: A normal finite number (exponent neither 0 nor all ones, bit 63 set) gives C3=0, C2=1, C0=0.
- R8: C1 always equals operand bit 79, including when the empty tag is high.
- R9: Every input pair selects exactly one class. The outputs settle combinationally within the same cycle, with no clock edge in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opValue | input | 80 | Operand: sign at 79, exponent at 78:64, significand at 63:0 (integer bit 63) |
| regEmpty | input | 1 | High when the operand's register is tagged empty |
| ccC3 | output | 1 | Condition bit C3 |
| ccC2 | output | 1 | Condition bit C2 |
| ccC1 | output | 1 | Condition bit C1 (sign) |
| ccC0 | output | 1 | Condition bit C0 |

## Verification
Every result of this block is due zero cycles after its stimulus, because no register lies between an operand and the four condition bits. The bench drives each vector on the falling clock edge and samples one nanosecond later, well before the next rising edge. This keeps any check from depending on the ordering of processes at an edge. One directed check changes the operand between clock edges and samples again before any edge arrives, which shows that the outputs follow the inputs with no clock in the path.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

  // One strobe per class, produced by the field decode.
  typedef struct packed {
    logic isEmpty;
    logic isZero;
    logic isNan;
    logic isUnsup;
    logic isInf;
    logic isDenorm;
    logic isNormal;
    logic signBit;
  } xfc_strobe_t;

  typedef struct packed {
    logic c3;
    logic c2;
    logic c1;
    logic c0;
  } xfc_cc_t;

endpackage

// File: rtl/xfc_field_decode.sv
module xfc_field_decode
  import xfc_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  localparam int VAL_W = 1 + EXP_W + SIG_W
) (
  input  logic [VAL_W-1:0] opValue,
  input  logic             regEmpty,
  output xfc_strobe_t      strobes
);

  logic [EXP_W-1:0] expField;
  logic [SIG_W-1:0] sigField;
  logic expAllOnes;
  logic expZero;
  logic intBit;
  logic fracZero;
  logic sigZero;

  assign expField   = opValue[VAL_W-2 -: EXP_W];
  assign sigField   = opValue[SIG_W-1:0];
  assign expAllOnes = &expField;
  assign expZero    = ~|expField;
  assign intBit     = sigField[SIG_W-1];
  assign fracZero   = ~|sigField[SIG_W-2:0];
  assign sigZero    = fracZero & ~intBit;

  always_comb begin
    strobes          = '0;
    strobes.signBit  = opValue[VAL_W-1];
    if (regEmpty) begin
      strobes.isEmpty = 1'b1;
    end else if (expZero) begin
      strobes.isZero   = sigZero;
      strobes.isDenorm = ~sigZero;
    end else if (!intBit) begin
      strobes.isUnsup = 1'b1;
    end else if (expAllOnes) begin
      strobes.isInf = fracZero;
      strobes.isNan = ~fracZero;
    end else begin
      strobes.isNormal = 1'b1;
    end
  end

  always_comb begin
    if (!regEmpty && expZero && !sigZero)
      AST_DENORM_STROBE: assert (strobes.isDenorm) else $error("denormal strobe missing"); // R6
  end

endmodule

// File: rtl/xfc_cc_encode.sv
module xfc_cc_encode
  import xfc_pkg::*;
(
  input  xfc_strobe_t strobes,
  output xfc_cc_t     ccOut
);

  logic [6:0] classVec;

  assign classVec = {strobes.isEmpty, strobes.isZero, strobes.isNan, strobes.isUnsup,
                     strobes.isInf, strobes.isDenorm, strobes.isNormal};

  always_comb begin
    ccOut    = '0;
    ccOut.c1 = strobes.signBit;
    unique case (1'b1)
      strobes.isEmpty:  begin ccOut.c3 = 1'b1; ccOut.c0 = 1'b1; end
      strobes.isZero:   begin ccOut.c3 = 1'b1; end
      strobes.isNan:    begin ccOut.c0 = 1'b1; end
      strobes.isInf:    begin ccOut.c2 = 1'b1; ccOut.c0 = 1'b1; end
      strobes.isDenorm: begin ccOut.c3 = 1'b1; ccOut.c2 = 1'b1; end
      strobes.isNormal: begin ccOut.c2 = 1'b1; end
      default:          begin end
    endcase
  end

  always_comb begin
    AST_ONE_CLASS: assert ($onehot(classVec)) else $error("class strobes not one-hot"); // R9
    if (strobes.isEmpty)
      AST_EMPTY_CODE: assert (ccOut.c3 && ccOut.c0 && !ccOut.c2) else $error("empty code wrong"); // R1
  end

endmodule

// File: rtl/xfc_examiner.sv
module xfc_examiner
  import xfc_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  localparam int VAL_W = 1 + EXP_W + SIG_W
) (
  input  logic [VAL_W-1:0] opValue,
  input  logic             regEmpty,
  output logic             ccC3,
  output logic             ccC2,
  output logic             ccC1,
  output logic             ccC0
);

  xfc_strobe_t strobes;
  xfc_cc_t     ccOut;

  xfc_field_decode #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_decode (
    .opValue  (opValue),
    .regEmpty (regEmpty),
    .strobes  (strobes)
  );

  xfc_cc_encode u_encode (
    .strobes (strobes),
    .ccOut   (ccOut)
  );

  assign ccC3 = ccOut.c3;
  assign ccC2 = ccOut.c2;
  assign ccC1 = ccOut.c1;
  assign ccC0 = ccOut.c0;

  always_comb begin
    AST_SIGN_PASS: assert (ccC1 == opValue[VAL_W-1]) else $error("sign not passed"); // R8
    if (!regEmpty && (|opValue[VAL_W-2 -: EXP_W]) && !opValue[SIG_W-1])
      AST_UNSUP_QUIET: assert (!ccC3 && !ccC2 && !ccC0) else $error("unsupported code wrong"); // R4
    if (!regEmpty && (&opValue[VAL_W-2 -: EXP_W]) && opValue[SIG_W-1] && !(|opValue[SIG_W-2:0]))
      AST_INF_CODE: assert (!ccC3 && ccC2 && ccC0) else $error("infinity code wrong"); // R5
  end

endmodule

// File: tb/xfc_examiner_bench.sv
module xfc_examiner_bench;

  // Vector: {empty, value[79:0], expected {C3,C2,C1,C0}, requirement number}
  localparam int NVEC = 17;
  localparam logic [92:0] VEC [NVEC] = '{
    {1'b0, 80'h00000000000000000000, 4'b1000, 8'd2}, // R2 +zero
    {1'b0, 80'h80000000000000000000, 4'b1010, 8'd2}, // R2 -zero
    {1'b0, 80'h3FFF8000000000000000, 4'b0100, 8'd7}, // R7 +1.0
    {1'b0, 80'hC000C000000000000000, 4'b0110, 8'd7}, // R7 -3.0
    {1'b0, 80'h7FFEFFFFFFFFFFFFFFFF, 4'b0100, 8'd7}, // R7 largest normal
    {1'b0, 80'h00018000000000000000, 4'b0100, 8'd7}, // R7 smallest normal
    {1'b0, 80'h7FFF8000000000000000, 4'b0101, 8'd5}, // R5 +inf
    {1'b0, 80'hFFFF8000000000000000, 4'b0111, 8'd5}, // R5 -inf
    {1'b0, 80'h7FFFC000000000000000, 4'b0001, 8'd3}, // R3 quiet NaN
    {1'b0, 80'hFFFF8000000000000001, 4'b0011, 8'd3}, // R3 signalling NaN, low bit
    {1'b0, 80'h7FFF0000000000000000, 4'b0000, 8'd4}, // R4 all-ones exp, int bit clear
    {1'b0, 80'h40004000000000000000, 4'b0000, 8'd4}, // R4 unnormal
    {1'b0, 80'h80010000000000000001, 4'b0010, 8'd4}, // R4 negative unsupported
    {1'b0, 80'h00000000000000000001, 4'b1100, 8'd6}, // R6 denormal
    {1'b0, 80'h80008000000000000000, 4'b1110, 8'd6}, // R6 int bit set, exp zero
    {1'b1, 80'h3FFF8000000000000000, 4'b1001, 8'd1}, // R1 empty over a normal
    {1'b1, 80'hFFFFC000000000000000, 4'b1011, 8'd1}  // R1 R8 empty, sign kept
  };

  logic        clk = 1'b0;
  logic [79:0] opValue = '0;
  logic        regEmpty = 1'b0;
  logic        ccC3, ccC2, ccC1, ccC0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  xfc_examiner u_xfc_examiner (
    .opValue  (opValue),
    .regEmpty (regEmpty),
    .ccC3     (ccC3),
    .ccC2     (ccC2),
    .ccC1     (ccC1),
    .ccC0     (ccC0)
  );

  task automatic check_cc(input logic [3:0] expCc, input string req);
    logic [3:0] got;
    got = {ccC3, ccC2, ccC1, ccC0};
    checks++;
    if (got !== expCc) begin
      fails++;
      $display("FAIL %s value=%h empty=%b got=%b expected=%b", req, opValue, regEmpty, got, expCc);
    end
  endtask

  initial begin
    // Power-up state: zero operand, not empty (R2)
    @(negedge clk);
    #1 check_cc(4'b1000, "R2");

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      regEmpty = VEC[i][92];
      opValue  = VEC[i][91:12];
      #1 check_cc(VEC[i][11:8], $sformatf("R%0d", VEC[i][7:0]));
    end

    // R8: sign follows bit 79 for every class, empty included
    @(negedge clk);
    regEmpty = 1'b1; opValue = 80'h80000000000000000000;
    #1 check_cc(4'b1011, "R8");
    regEmpty = 1'b0;
    #1 check_cc(4'b1010, "R8");

    // R9: change between edges, outputs follow with no clock edge
    @(posedge clk);
    #2 opValue = 80'h7FFF8000000000000000;
    #1 check_cc(4'b0101, "R9");
    opValue = 80'h00000000000000000003;
    #1 check_cc(4'b1100, "R9");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule